// File: doc/BRIEF.md
# Dual Bidirectional Parallel Port

This block provides two parallel I/O ports of `W` bits each. Every port holds an output data value and a direction mask. A small register interface writes and reads back all four of these values. A direction bit of 1 makes its pin an output. A direction bit of 0 leaves the pin undriven, and the pin then sits high through its pull-up. The block takes the level seen on each external pin and drives the effective level of each pin.

Reading a data register returns a wired-AND view of the pin. Port A combines the pull-up, the driven value and the external signal, so either side can pull a bit low. Port B masks the external signal with the direction bits, so an output bit reads back the value that was written. A strobe pulses for one cycle after each write to either port A register, so logic attached to port A can sample the new levels. Read data is registered and appears with a valid pulse one cycle after the request.

Top module: `dpio_top`

## Requirements
- R1: After reset, both data registers and both direction registers hold zero. Every pin then drives high, and direction reads return 0.
- R2: The register address selects a register as follows: 0 is port A data, 1 is port A direction, 2 is port B data and 3 is port B direction.
- R3: Each pin level equals (data OR NOT direction), bit by bit, from the cycle after the write that changed it.
- R4: A port A data read returns (data OR NOT direction) AND the external port A value.
- R5: A port B data read returns (data OR NOT direction) AND (external port B value OR direction).
- R6: A direction read returns the stored mask unchanged.
- R7: A read request taken at a clock edge presents `rd_data` with `rd_valid` high in the following cycle. Without a request, `rd_valid` stays low and `rd_data` holds its value.
- R8: `pins_a_upd` is high for exactly one cycle after a write to address 0 or 1. Writes to address 2 or 3 do not raise it.
- R9: Writes to port B registers leave the port A pins unchanged. Writes to port A registers leave the port B pins unchanged.
- R10: A read changes no register: the same read issued twice returns the same value while the inputs are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write request for the addressed register |
| rd_en | input | 1 | Read request for the addressed register |
| addr | input | 2 | Register select |
| wr_data | input | W | Write value |
| rd_data | output | W | Registered read value |
| rd_valid | output | 1 | High for one cycle when rd_data is new |
| ext_a | input | W | Levels seen on the port A pins from outside |
| ext_b | input | W | Levels seen on the port B pins from outside |
| pins_a | output | W | Effective driven level of the port A pins |
| pins_b | output | W | Effective driven level of the port B pins |
| pins_a_upd | output | 1 | One-cycle pulse after a port A register write |

## Verification
The assertions assume that the request inputs are never X after reset. They also assume that the port B pins change only as the result of a write to address 2 or 3. The stimulus keeps `wr_en` and `rd_en` low unless a task drives them. It never raises both in the same cycle, and it changes `ext_a` and `ext_b` only between reads. The read checks use a range of direction masks: all inputs, all outputs and mixed patterns. They pair each mask with external values that pull down bits the port also drives, so the different read compositions of the two ports produce different results.

// File: rtl/dpio_pkg.sv
package dpio_pkg;
    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        SEL_A_DATA = 2'd0,
        SEL_A_DIR  = 2'd1,
        SEL_B_DATA = 2'd2,
        SEL_B_DIR  = 2'd3
    } dpio_sel_e;

    // read composition variants for a port
    localparam int RB_WIRED_AND  = 0;  // external pins may pull any bit low
    localparam int RB_MASK_BY_DIR = 1; // output bits read back written data
endpackage

// File: rtl/dpio_regs.sv
module dpio_regs
    import dpio_pkg::*;
#(
    parameter int W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [W-1:0]        wr_data,
    output logic [W-1:0]        a_data,
    output logic [W-1:0]        a_dir,
    output logic [W-1:0]        b_data,
    output logic [W-1:0]        b_dir,
    output logic                a_upd
);
    typedef struct packed {
        logic [W-1:0] a_data;
        logic [W-1:0] a_dir;
        logic [W-1:0] b_data;
        logic [W-1:0] b_dir;
        logic         a_upd;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.a_upd = 1'b0;
        if (wr_en) begin
            unique case (dpio_sel_e'(addr))
                SEL_A_DATA: begin st_d.a_data = wr_data; st_d.a_upd = 1'b1; end
                SEL_A_DIR:  begin st_d.a_dir  = wr_data; st_d.a_upd = 1'b1; end
                SEL_B_DATA: st_d.b_data = wr_data;
                SEL_B_DIR:  st_d.b_dir  = wr_data;
                default:    ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign a_data = st_q.a_data;
    assign a_dir  = st_q.a_dir;
    assign b_data = st_q.b_data;
    assign b_dir  = st_q.b_dir;
    assign a_upd  = st_q.a_upd;

    assert_strobe_on_a_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (addr == SEL_A_DATA || addr == SEL_A_DIR)) |=> a_upd);
    assert_no_strobe_otherwise_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && (addr == SEL_A_DATA || addr == SEL_A_DIR)) |=> !a_upd);
    assert_dir_b_stored_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == SEL_B_DIR) |=> (b_dir == $past(wr_data)));
endmodule

// File: rtl/dpio_port.sv
module dpio_port
    import dpio_pkg::*;
#(
    parameter int W       = 8,
    parameter int RB_MODE = RB_WIRED_AND
) (
    input  logic [W-1:0] data,
    input  logic [W-1:0] dir,
    input  logic [W-1:0] ext,
    output logic [W-1:0] pins,
    output logic [W-1:0] rd_val
);
    // undriven bits float high through the pull-up
    assign pins = data | ~dir;

    generate
        if (RB_MODE == RB_WIRED_AND) begin : g_wired
            assign rd_val = pins & ext;
        end else begin : g_masked
            assign rd_val = pins & (ext | dir);
        end
    endgenerate
endmodule

// File: rtl/dpio_rdmux.sv
module dpio_rdmux
    import dpio_pkg::*;
#(
    parameter int W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rd_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [W-1:0]        a_val,
    input  logic [W-1:0]        a_dir,
    input  logic [W-1:0]        b_val,
    input  logic [W-1:0]        b_dir,
    output logic [W-1:0]        rd_data,
    output logic                rd_valid
);
    typedef struct packed {
        logic [W-1:0] data;
        logic         valid;
    } rd_t;

    rd_t rd_d, rd_q;

    always_comb begin
        rd_d       = rd_q;
        rd_d.valid = rd_en;
        if (rd_en) begin
            unique case (dpio_sel_e'(addr))
                SEL_A_DATA: rd_d.data = a_val;
                SEL_A_DIR:  rd_d.data = a_dir;
                SEL_B_DATA: rd_d.data = b_val;
                SEL_B_DIR:  rd_d.data = b_dir;
                default:    ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign rd_data  = rd_q.data;
    assign rd_valid = rd_q.valid;

    assert_valid_follows_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);
    assert_idle_holds_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> (!rd_valid && $stable(rd_data)));
endmodule

// File: rtl/dpio_top.sv
module dpio_top
    import dpio_pkg::*;
#(
    parameter int W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [1:0]        addr,
    input  logic [W-1:0]      wr_data,
    output logic [W-1:0]      rd_data,
    output logic              rd_valid,
    input  logic [W-1:0]      ext_a,
    input  logic [W-1:0]      ext_b,
    output logic [W-1:0]      pins_a,
    output logic [W-1:0]      pins_b,
    output logic              pins_a_upd
);
    logic [W-1:0] a_data, a_dir, b_data, b_dir;
    logic [W-1:0] a_rd, b_rd;

    dpio_regs #(.W(W)) regs_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
        .a_data(a_data), .a_dir(a_dir), .b_data(b_data), .b_dir(b_dir),
        .a_upd(pins_a_upd)
    );

    dpio_port #(.W(W), .RB_MODE(RB_WIRED_AND)) port_a_i (
        .data(a_data), .dir(a_dir), .ext(ext_a), .pins(pins_a), .rd_val(a_rd)
    );

    dpio_port #(.W(W), .RB_MODE(RB_MASK_BY_DIR)) port_b_i (
        .data(b_data), .dir(b_dir), .ext(ext_b), .pins(pins_b), .rd_val(b_rd)
    );

    dpio_rdmux #(.W(W)) rdmux_i (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .addr(addr),
        .a_val(a_rd), .a_dir(a_dir), .b_val(b_rd), .b_dir(b_dir),
        .rd_data(rd_data), .rd_valid(rd_valid)
    );

    assert_b_pins_isolated_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && (addr == SEL_B_DATA || addr == SEL_B_DIR)) |=> $stable(pins_b));
    assert_a_pins_isolated_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && (addr == SEL_A_DATA || addr == SEL_A_DIR)) |=> $stable(pins_a));
endmodule

// File: tb/dpio_top_tb.sv
module dpio_top_tb_top;
    localparam int W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0, rd_en = 1'b0;
    logic [1:0] addr = '0;
    logic [W-1:0] wr_data = '0, ext_a = '1, ext_b = '1;
    logic [W-1:0] rd_data, pins_a, pins_b;
    logic rd_valid, pins_a_upd;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // bench model of the registers
    logic [W-1:0] m_ad = '0, m_ar = '0, m_bd = '0, m_br = '0;

    typedef struct {
        logic [W-1:0] val;
        string        tag;
    } exp_t;
    exp_t sb_q[$];

    always #5 clk = ~clk;

    dpio_top #(.W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wr_data(wr_data), .rd_data(rd_data), .rd_valid(rd_valid),
        .ext_a(ext_a), .ext_b(ext_b), .pins_a(pins_a), .pins_b(pins_b),
        .pins_a_upd(pins_a_upd)
    );

    task automatic check(input logic [W-1:0] act, input logic [W-1:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [W-1:0] lvl(input logic [W-1:0] d, input logic [W-1:0] r);
        return d | ~r;
    endfunction

    // monitor: pops and compares at every valid read
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (sb_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R7: actual unexpected rd_valid expected none");
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                check(rd_data, e.val, e.tag);
            end
        end
    end

    task automatic wr(input logic [1:0] a, input logic [W-1:0] v);
        wr_en = 1'b1; addr = a; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
        case (a)
            2'd0: m_ad = v;
            2'd1: m_ar = v;
            2'd2: m_bd = v;
            default: m_br = v;
        endcase
        // registers have updated at the edge just passed
        check(pins_a, lvl(m_ad, m_ar), "R3 pins_a");
        check(pins_b, lvl(m_bd, m_br), "R3/R9 pins_b");
        check({{(W-1){1'b0}}, pins_a_upd}, {{(W-1){1'b0}}, (a < 2'd2)}, "R8 strobe");
        @(negedge clk);
        check({{(W-1){1'b0}}, pins_a_upd}, '0, "R8 strobe width");
    endtask

    task automatic rd(input logic [1:0] a, input string tag);
        exp_t e;
        case (a)
            2'd0: e.val = lvl(m_ad, m_ar) & ext_a;
            2'd1: e.val = m_ar;
            2'd2: e.val = lvl(m_bd, m_br) & (ext_b | m_br);
            default: e.val = m_br;
        endcase
        e.tag = tag;
        sb_q.push_back(e);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    initial begin
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(pins_a, '1, "R1 pins_a after reset");
        check(pins_b, '1, "R1 pins_b after reset");
        rd(2'd1, "R1 dir A reset");
        rd(2'd3, "R1 dir B reset");
        ext_a = 8'h5A;
        rd(2'd0, "R1 data A reset");
        @(negedge clk);
        check({7'b0, rd_valid}, '0, "R7 no valid when idle");

        // R2 / R6: distinct values to each address
        wr(2'd0, 8'h3C);
        wr(2'd1, 8'hF0);
        wr(2'd2, 8'hA5);
        wr(2'd3, 8'h0F);
        rd(2'd1, "R2/R6 dir A");
        rd(2'd3, "R2/R6 dir B");

        // R4: port A wired-AND with mixed direction
        ext_a = 8'hFF; rd(2'd0, "R4 A ext high");
        ext_a = 8'h00; rd(2'd0, "R4 A ext low");
        ext_a = 8'h96; rd(2'd0, "R4 A ext mixed");
        rd(2'd0, "R10 repeat read");

        // R5: port B masks external by direction
        ext_b = 8'h00; rd(2'd2, "R5 B ext low");
        ext_b = 8'h69; rd(2'd2, "R5 B ext mixed");
        rd(2'd2, "R10 repeat read B");

        // all outputs / all inputs
        wr(2'd3, 8'hFF); wr(2'd2, 8'h81);
        ext_b = 8'h00; rd(2'd2, "R5 B all outputs");
        wr(2'd1, 8'h00);
        ext_a = 8'hC3; rd(2'd0, "R4 A all inputs");
        wr(2'd1, 8'hFF); wr(2'd0, 8'h00);
        ext_a = 8'hFF; rd(2'd0, "R4 A driven zero");
        rd(2'd1, "R6 dir A all ones");

        repeat (3) @(negedge clk);
        check(W'(sb_q.size()), '0, "R7 all reads answered");
        done = 1'b1;
    end

    initial begin
        repeat (5000) @(negedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        done = 1'b1;
    end

    initial begin
        wait (done);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule